// File: doc/BRIEF.md
# Strap capture and frequency-code source selector

This block owns a group of five shared pins that serve two purposes. While the chip is held in power-on reset, the pins are inputs. Their levels, set by board resistors, are synchronized and held in a five-bit hold register. These levels are four frequency-select straps and one select for the 24/48 MHz output. When reset ends, the block switches the pins to their clock-output role. From then on the held values stay fixed, whatever the pins do.

The block also delivers a five-bit frequency code to the divider logic downstream. One bit of the first configuration byte chooses where the code comes from. When that bit is 0, the code comes from the held straps. When it is 1, the code comes from programmed fields of the same byte. The held straps are also exported so that the register block can return them on readback.

Top module: `strap_cfg_ctrl`

## Requirements
- R1: A strap value held on `strap_in` for at least the last three reset cycles is the value found in `strap_rb` once reset is released (two synchronizer stages, then capture on every reset edge).
- R2: After reset is released, `strap_rb` never changes, whatever `strap_in` does.
- R3: While `rst` is high, `pad_oe` and `pad_out` are all zeros from the first clock edge on, so no pad toggles.
- R4: From the first edge with `rst` low, `pad_oe` is all ones and `pad_out` equals the `clk_int` value presented before that edge.
- R5: When `cfg_byte[3]` is 0 (hardware source), `freq_code` one edge later equals `{1'b0, strap_rb[3:0]}`.
- R6: When `cfg_byte[3]` is 1 (software source), `freq_code` one edge later equals `{cfg_byte[2], cfg_byte[1], cfg_byte[6], cfg_byte[5], cfg_byte[4]}`.
- R7: While `rst` is high, `freq_code` is 0 and `sw_active` is 0, even if `cfg_byte[3]` is 1. After reset, `sw_active` follows `cfg_byte[3]` one edge later, and the source changes only on a clock edge.
- R8: `strap_rb` bit i (i = 0 to 3) holds frequency strap i. Bit 4 holds the 24/48 MHz select strap. `strap_in` uses the same positions.
- R9: Bits 0 and 7 of `cfg_byte` have no effect on `freq_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset; straps are captured while it is high |
| strap_in | input | 5 | Pin levels seen in input mode: [3:0] frequency straps, [4] 24/48 select |
| clk_int | input | 5 | Internal clock values to drive onto the shared pins after reset |
| cfg_byte | input | 8 | First configuration byte: [3] source select, [2:1] and [6:4] software code |
| pad_out | output | 5 | Registered output values for the shared pins |
| pad_oe | output | 5 | Per-pin output enable, low during reset |
| strap_rb | output | 5 | Held strap values for register readback |
| freq_code | output | 5 | Registered frequency code sent to the dividers |
| sw_active | output | 1 | High when the software source drives `freq_code` |

## Verification
The bench changes the straps partway through reset. It checks that only the value present in the final reset cycles is kept. A design that captures on the first reset cycle, or that skips the synchronizer delay, would hold the earlier value. After release the bench drives the strap pins with the inverse of the held value and with random values, so a hold register that keeps sampling would show a changed readback. It sets the source select during reset to catch a code that leaks out before release. It also flips configuration bits 0 and 7 and uses an asymmetric strap pattern, which exposes swapped fields in the software code and bit-order errors in readback.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  localparam int FS_BITS    = 4;
  localparam int STRAP_BITS = FS_BITS + 1;
  localparam int CODE_BITS  = 5;
  localparam int CFG_BITS   = 8;
  localparam int SRC_SEL_BIT = 3;

  // Software code: programmed bits 2:1 above bits 6:4 of the configuration byte
  function automatic logic [CODE_BITS-1:0] sw_code(input logic [CFG_BITS-1:0] c);
    return {c[2], c[1], c[6], c[5], c[4]};
  endfunction

  // Hardware code: held frequency straps with a zero on top
  function automatic logic [CODE_BITS-1:0] hw_code(input logic [STRAP_BITS-1:0] s);
    return {{(CODE_BITS-FS_BITS){1'b0}}, s[FS_BITS-1:0]};
  endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) chain[g] <= d;
      end else begin : g_next
        always_ff @(posedge clk) chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/strap_hold.sv
module strap_hold #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         capture,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  always_ff @(posedge clk) begin
    if (capture) held <= d;
  end

  assign q = held;
endmodule

// File: rtl/pad_turnover.sv
module pad_turnover #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] clk_int,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  logic [W-1:0] out_q;
  logic [W-1:0] oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      out_q <= clk_int;
      oe_q  <= '1;
    end
  end

  assign pad_out = out_q;
  assign pad_oe  = oe_q;
endmodule

// File: rtl/fsel_mux.sv
module fsel_mux
  import strap_cfg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CFG_BITS-1:0]   cfg_byte,
  input  logic [STRAP_BITS-1:0] held,
  output logic [CODE_BITS-1:0]  code,
  output logic                  sw_active
);
  logic [CODE_BITS-1:0] code_q;
  logic                 sw_q;
  logic [CODE_BITS-1:0] code_d;

  always_comb begin
    if (cfg_byte[SRC_SEL_BIT]) code_d = sw_code(cfg_byte);
    else                       code_d = hw_code(held);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      sw_q   <= 1'b0;
    end else begin
      code_q <= code_d;
      sw_q   <= cfg_byte[SRC_SEL_BIT];
    end
  end

  assign code      = code_q;
  assign sw_active = sw_q;
endmodule

// File: rtl/strap_cfg_ctrl.sv
module strap_cfg_ctrl
  import strap_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [STRAP_BITS-1:0] strap_in,
  input  logic [STRAP_BITS-1:0] clk_int,
  input  logic [CFG_BITS-1:0]   cfg_byte,
  output logic [STRAP_BITS-1:0] pad_out,
  output logic [STRAP_BITS-1:0] pad_oe,
  output logic [STRAP_BITS-1:0] strap_rb,
  output logic [CODE_BITS-1:0]  freq_code,
  output logic                  sw_active
);
  logic [STRAP_BITS-1:0] strap_s;
  logic [STRAP_BITS-1:0] held;

  strap_sync #(.W(STRAP_BITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (strap_in),
    .q   (strap_s)
  );

  strap_hold #(.W(STRAP_BITS)) u_hold (
    .clk     (clk),
    .capture (rst),
    .d       (strap_s),
    .q       (held)
  );

  pad_turnover #(.W(STRAP_BITS)) u_pads (
    .clk     (clk),
    .rst     (rst),
    .clk_int (clk_int),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  fsel_mux u_fsel (
    .clk       (clk),
    .rst       (rst),
    .cfg_byte  (cfg_byte),
    .held      (held),
    .code      (freq_code),
    .sw_active (sw_active)
  );

  assign strap_rb = held;
endmodule

// File: rtl/strap_cfg_chk.sv
module strap_cfg_chk
  import strap_cfg_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic [STRAP_BITS-1:0] strap_in,
  input logic [STRAP_BITS-1:0] clk_int,
  input logic [CFG_BITS-1:0]   cfg_byte,
  input logic [STRAP_BITS-1:0] pad_out,
  input logic [STRAP_BITS-1:0] pad_oe,
  input logic [STRAP_BITS-1:0] strap_rb,
  input logic [CODE_BITS-1:0]  freq_code,
  input logic                  sw_active
);
  // R3: pads quiet during reset
  a_r3_pads_quiet: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0 && freq_code == '0 && !sw_active));

  // R2: held straps frozen after release
  a_r2_hold_frozen: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(strap_rb));

  // R4: pads driven after release
  a_r4_pads_drive: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pad_oe == '1 && pad_out == $past(clk_int)));

  // R5: hardware source
  a_r5_hw_code: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cfg_byte[SRC_SEL_BIT])) |->
      (freq_code == {1'b0, strap_rb[3:0]} && !sw_active));

  // R6: software source
  a_r6_sw_code: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_byte[SRC_SEL_BIT])) |->
      (freq_code == {$past(cfg_byte[2]), $past(cfg_byte[1]), $past(cfg_byte[6]),
                     $past(cfg_byte[5]), $past(cfg_byte[4])} && sw_active));
endmodule

bind strap_cfg_ctrl strap_cfg_chk i_chk (.*);

// File: tb/test_strap_cfg_ctrl.sv
module test_strap_cfg_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] strap_in = 5'h1f;
  logic [4:0] clk_int = '0;
  logic [7:0] cfg_byte = '0;
  logic [4:0] pad_out, pad_oe, strap_rb, freq_code;
  logic       sw_active;

  int  vecs = 0;
  int  bad  = 0;
  bit  done = 0;
  logic [4:0] latched = '0;

  always #5 clk = ~clk;

  strap_cfg_ctrl i_strap_cfg_ctrl (
    .clk(clk), .rst(rst), .strap_in(strap_in), .clk_int(clk_int),
    .cfg_byte(cfg_byte), .pad_out(pad_out), .pad_oe(pad_oe),
    .strap_rb(strap_rb), .freq_code(freq_code), .sw_active(sw_active)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    vecs++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [4:0] exp_code(input logic [7:0] c, input logic [4:0] s);
    return c[3] ? {c[2], c[1], c[6], c[5], c[4]} : {1'b0, s[3:0]};
  endfunction

  task automatic reset_round(input logic [4:0] early, input logic [4:0] final_v, input int hold);
    rst = 1'b1;
    strap_in = early;
    cfg_byte = 8'h08;
    clk_int = 5'h1f;
    step;
    step;
    strap_in = final_v;
    for (int i = 0; i < hold; i++) begin
      clk_int  = 5'($urandom);
      cfg_byte = 8'($urandom) | 8'h08;
      step;
      chk("R3 oe in reset", 8'(pad_oe), 8'h00);
      chk("R3 out in reset", 8'(pad_out), 8'h00);
      chk("R7 code in reset", 8'(freq_code), 8'h00);
      chk("R7 sw in reset", 8'(sw_active), 8'h00);
    end
    rst = 1'b0;
    strap_in = ~final_v;
    latched = final_v;
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] c;
      logic [4:0] k;
      c = 8'($urandom);
      k = 5'($urandom);
      cfg_byte = c;
      clk_int  = k;
      step;
      strap_in = 5'($urandom);
      chk("R4 oe", 8'(pad_oe), 8'h1f);
      chk("R4 out", 8'(pad_out), 8'(k));
      chk("R1 R2 held", 8'(strap_rb), 8'(latched));
      chk(c[3] ? "R6 sw code" : "R5 hw code", 8'(freq_code), 8'(exp_code(c, latched)));
      chk("R7 sw flag", 8'(sw_active), 8'(c[3]));
    end
  endtask

  initial begin
    logic [4:0] base_code;
    void'($urandom(32'd1357));
    // R1 pull-up style all-ones straps, then all zeros
    reset_round(5'h00, 5'h1f, 3);
    run_cycles(20);
    reset_round(5'h1f, 5'h00, 4);
    run_cycles(20);
    // R8 asymmetric pattern for bit order
    reset_round(5'h09, 5'h16, 5);
    cfg_byte = 8'h00;
    step;
    chk("R8 readback order", 8'(strap_rb), 8'h16);
    chk("R8 hw code order", 8'(freq_code), 8'h06);
    // R9 bits 0 and 7 ignored in software mode
    cfg_byte = 8'h5c;
    step;
    base_code = freq_code;
    chk("R6 directed", 8'(freq_code), 8'h15);
    cfg_byte = 8'h5c ^ 8'h81;
    step;
    chk("R9 bits 0/7 ignored sw", 8'(freq_code), 8'(base_code));
    cfg_byte = 8'h81;
    step;
    chk("R9 bits 0/7 ignored hw", 8'(freq_code), 8'h06);
    // random rounds
    for (int r = 0; r < 30; r++) begin
      reset_round(5'($urandom), 5'($urandom), 3 + int'($urandom % 6));
      run_cycles(40);
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      vecs++;
      bad++;
      $display("FAIL watchdog expired got 1 exp 0");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule